// File: doc/BRIEF.md
# Dual/Single Pixel Link Rate Converter

This block sits between a parallel pixel receiver and a parallel pixel transmitter. It reformats 30-bit pixel streams between one-link and two-link layouts. There are two input links and two output links. Each link is a 30-bit pixel bus with a valid strobe. The pixel rate of a link is the density of its valid strobes on the shared clock. The word is made of five 6-bit lanes: lane A is bits 5:0, B is 11:6, C is 17:12, D is 23:18 and E is 29:24.

A 2-bit mode input selects one of four conversions:
- Pass-through: each input link feeds its own output link.
- Duplication: link 1 is copied onto both output links.
- Splitting: one input link is spread over two output links, each at half rate.
- Merging: two input links are folded onto one output link at double rate.

A power-down input forces both output links into the disabled state. So does a clock-present flag for link 1. A second clock-present flag qualifies link 2. Per-lane present flags replace a missing input lane with zeros.

All outputs are registered, so a result appears one clock after the input that completes it.

Top module: `link_rate_conv`

## Requirements
- R1: With mode 2'b00 (pass-through), a valid pixel on input link 1 appears unchanged on output link 1 one clock later, and a valid pixel on input link 2 appears on output link 2 one clock later.
- R2: With mode 2'b10 (duplication), every valid pixel on input link 1 appears on both output links in the same cycle, one clock later. Input link 2 data, its valid strobe and its clock-present flag have no effect, and both output enables are high.
- R3: With mode 2'b11 (splitting), input link 1 pixels are numbered from 0 after the last mode change or disable. Each even pixel is held. When the next odd pixel arrives, the held even pixel is presented on output link 1 and the odd pixel on output link 2, together, one clock later.
- R4: With mode 2'b01 (merging), a cycle in which both input links are valid presents the link 1 pixel on output link 1 one clock later and the link 2 pixel on the following clock. Output link 2 is disabled (enable low, valid low). Pairs must be spaced at least two cycles apart; a pair arriving while a link 2 pixel is still pending is dropped.
- R5: While power-down is high, both output enables and valids are low one clock later, whatever the mode or inputs, and any split or merge phase is cleared.
- R6: While the link 1 clock-present flag is low, both output enables and valids are low one clock later, and any split or merge phase is cleared.
- R7: In modes 2'b00 and 2'b01, a low link 2 clock-present flag makes input link 2 count as not valid. In modes 2'b10 and 2'b11 the flag is ignored.
- R8: A low per-lane present flag (bit 0 = lane A bits 5:0 up to bit 4 = lane E bits 29:24) makes that lane of the pixel from that input link read as zero on every output it reaches, while the other lanes pass unchanged.
- R9: In the cycle where the mode input differs from its value in the previous cycle, input pixels are discarded and the split/merge phase and any pending pixel are cleared. Both output valids are low one clock later.
- R10: During reset and in the first cycle after it, all output enables and valids are low and the output pixel buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Conversion mode select |
| pwr_dn | input | 1 | Power-down, high disables outputs |
| l1_clk_ok | input | 1 | Link 1 clock present |
| l2_clk_ok | input | 1 | Link 2 clock present |
| l1_lane_ok | input | 5 | Link 1 per-lane present flags |
| l2_lane_ok | input | 5 | Link 2 per-lane present flags |
| l1_vld | input | 1 | Input link 1 valid |
| l1_pix | input | 30 | Input link 1 pixel |
| l2_vld | input | 1 | Input link 2 valid |
| l2_pix | input | 30 | Input link 2 pixel |
| o1_en | output | 1 | Output link 1 enable |
| o1_vld | output | 1 | Output link 1 valid |
| o1_pix | output | 30 | Output link 1 pixel |
| o2_en | output | 1 | Output link 2 enable |
| o2_vld | output | 1 | Output link 2 valid |
| o2_pix | output | 30 | Output link 2 pixel |

## Verification
A wrong split phase shows as a swap: even pixels land on output link 2, or a pair is formed from the wrong neighbours. The scoreboard reports this on the first emitted pair. A stale merge pending register either shows as an extra pixel on output link 1 in the cycle after a pair, or as a missing second pixel. Either is seen within two clocks. A phase that survives a mode change or disable shows as a pixel from before the change, leaking into the first pair formed after it.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned LANES  = 5;
  localparam int unsigned LANE_W = 6;
  localparam int unsigned PIX_W  = LANES * LANE_W;

  typedef enum logic [1:0] {
    M_PASS  = 2'b00,
    M_MERGE = 2'b01,
    M_DUP   = 2'b10,
    M_SPLIT = 2'b11
  } mode_e;
endpackage

// File: rtl/rc_rst_sync.sv
module rc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/rc_lane_mask.sv
module rc_lane_mask #(
  parameter int unsigned LANES  = 5,
  parameter int unsigned LANE_W = 6,
  localparam int unsigned PIX_W = LANES * LANE_W
) (
  input  logic [LANES-1:0] lane_ok,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pix_out[g*LANE_W +: LANE_W] =
      lane_ok[g] ? pix_in[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/rc_fmt.sv
module rc_fmt
  import rc_pkg::*;
#(
  parameter int unsigned W = PIX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         active,
  input  logic         l2_clk_ok,
  input  logic         a_vld,
  input  logic [W-1:0] a_pix,
  input  logic         b_vld,
  input  logic [W-1:0] b_pix,
  output logic         o1_en,
  output logic         o1_vld,
  output logic [W-1:0] o1_pix,
  output logic         o2_en,
  output logic         o2_vld,
  output logic [W-1:0] o2_pix
);
  logic [1:0]   mode_q;
  logic         phase_q, phase_d;
  logic [W-1:0] hold_q, hold_d;
  logic         hold_ce;
  logic         en1_q, en2_q, en1_d, en2_d;
  logic         v1_q, v2_q, v1_d, v2_d;
  logic [W-1:0] p1_q, p2_q, p1_d, p2_d;
  logic         chg, b_ok;

  assign chg  = (mode != mode_q);
  assign b_ok = b_vld && l2_clk_ok;

  always_comb begin
    phase_d = phase_q;
    hold_d  = hold_q;
    hold_ce = 1'b0;
    v1_d    = 1'b0;
    v2_d    = 1'b0;
    p1_d    = '0;
    p2_d    = '0;
    en1_d   = active;
    en2_d   = active && (mode != M_MERGE);
    if (!active || chg) begin
      phase_d = 1'b0;
    end else begin
      unique case (mode)
        M_PASS: begin
          v1_d = a_vld;
          p1_d = a_vld ? a_pix : '0;
          v2_d = b_ok;
          p2_d = b_ok ? b_pix : '0;
        end
        M_DUP: begin
          v1_d = a_vld;
          v2_d = a_vld;
          p1_d = a_vld ? a_pix : '0;
          p2_d = a_vld ? a_pix : '0;
        end
        M_SPLIT: begin
          if (a_vld) begin
            if (!phase_q) begin
              hold_d  = a_pix;
              hold_ce = 1'b1;
              phase_d = 1'b1;
            end else begin
              v1_d    = 1'b1;
              v2_d    = 1'b1;
              p1_d    = hold_q;
              p2_d    = a_pix;
              phase_d = 1'b0;
            end
          end
        end
        default: begin
          if (phase_q) begin
            v1_d    = 1'b1;
            p1_d    = hold_q;
            phase_d = 1'b0;
          end else if (a_vld && b_ok) begin
            v1_d    = 1'b1;
            p1_d    = a_pix;
            hold_d  = b_pix;
            hold_ce = 1'b1;
            phase_d = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_PASS;
      phase_q <= 1'b0;
      en1_q   <= 1'b0;
      en2_q   <= 1'b0;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      p1_q    <= '0;
      p2_q    <= '0;
    end else begin
      mode_q  <= mode;
      phase_q <= phase_d;
      en1_q   <= en1_d;
      en2_q   <= en2_d;
      v1_q    <= v1_d;
      v2_q    <= v2_d;
      p1_q    <= p1_d;
      p2_q    <= p2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_ce) hold_q <= hold_d;
  end

  assign o1_en  = en1_q;
  assign o2_en  = en2_q;
  assign o1_vld = v1_q;
  assign o2_vld = v2_q;
  assign o1_pix = p1_q;
  assign o2_pix = p2_q;

  AST_OFF_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!o1_en && !o2_en && !o1_vld && !o2_vld)); // R5
  AST_MERGE_LINK2_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_MERGE) |=> (!o2_en && !o2_vld)); // R4
  AST_SPLIT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SPLIT) |=> (o1_vld == o2_vld)); // R3
  AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (!o1_vld && !o2_vld)); // R9
  AST_DUP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DUP && !chg) |=> (o1_vld == o2_vld && o1_pix == o2_pix)); // R2
endmodule

// File: rtl/link_rate_conv.sv
module link_rate_conv
  import rc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             pwr_dn,
  input  logic             l1_clk_ok,
  input  logic             l2_clk_ok,
  input  logic [LANES-1:0] l1_lane_ok,
  input  logic [LANES-1:0] l2_lane_ok,
  input  logic             l1_vld,
  input  logic [PIX_W-1:0] l1_pix,
  input  logic             l2_vld,
  input  logic [PIX_W-1:0] l2_pix,
  output logic             o1_en,
  output logic             o1_vld,
  output logic [PIX_W-1:0] o1_pix,
  output logic             o2_en,
  output logic             o2_vld,
  output logic [PIX_W-1:0] o2_pix
);
  logic             rst_s_n;
  logic [PIX_W-1:0] a_pix, b_pix;
  logic             active;

  rc_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  rc_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) i_mask_a (
    .lane_ok(l1_lane_ok), .pix_in(l1_pix), .pix_out(a_pix)
  );
  rc_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) i_mask_b (
    .lane_ok(l2_lane_ok), .pix_in(l2_pix), .pix_out(b_pix)
  );

  assign active = !pwr_dn && l1_clk_ok;

  rc_fmt #(.W(PIX_W)) i_fmt (
    .clk(clk), .rst_n(rst_s_n), .mode(mode), .active(active),
    .l2_clk_ok(l2_clk_ok),
    .a_vld(l1_vld), .a_pix(a_pix), .b_vld(l2_vld), .b_pix(b_pix),
    .o1_en(o1_en), .o1_vld(o1_vld), .o1_pix(o1_pix),
    .o2_en(o2_en), .o2_vld(o2_vld), .o2_pix(o2_pix)
  );

  AST_CLK1_LOSS: assert property (@(posedge clk) disable iff (!rst_s_n)
    !l1_clk_ok |=> (!o1_en && !o2_en)); // R6
  AST_PWRDN: assert property (@(posedge clk) disable iff (!rst_s_n)
    pwr_dn |=> (!o1_vld && !o2_vld)); // R5
endmodule

// File: tb/test_link_rate_conv.sv
module test_link_rate_conv;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        pwr_dn, l1_clk_ok, l2_clk_ok;
  logic [4:0]  l1_lane_ok, l2_lane_ok;
  logic        l1_vld, l2_vld;
  logic [29:0] l1_pix, l2_pix;
  logic        o1_en, o1_vld, o2_en, o2_vld;
  logic [29:0] o1_pix, o2_pix;

  int errors = 0;
  int checks = 0;
  logic [29:0] q1[$], q2[$];
  string       t1[$], t2[$];

  always #4 clk = ~clk;

  link_rate_conv i_link_rate_conv (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pwr_dn(pwr_dn),
    .l1_clk_ok(l1_clk_ok), .l2_clk_ok(l2_clk_ok),
    .l1_lane_ok(l1_lane_ok), .l2_lane_ok(l2_lane_ok),
    .l1_vld(l1_vld), .l1_pix(l1_pix), .l2_vld(l2_vld), .l2_pix(l2_pix),
    .o1_en(o1_en), .o1_vld(o1_vld), .o1_pix(o1_pix),
    .o2_en(o2_en), .o2_vld(o2_vld), .o2_pix(o2_pix)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops
  always @(negedge clk) begin
    if (rst_n) begin
      if (o1_vld) begin
        checks++;
        if (q1.size() == 0) begin
          errors++;
          $display("FAIL unexpected link1: actual %h expected none", o1_pix);
        end else begin
          logic [29:0] e; string r;
          e = q1.pop_front(); r = t1.pop_front();
          if (o1_pix !== e) begin
            errors++;
            $display("FAIL %s link1: actual %h expected %h", r, o1_pix, e);
          end
        end
      end
      if (o2_vld) begin
        checks++;
        if (q2.size() == 0) begin
          errors++;
          $display("FAIL unexpected link2: actual %h expected none", o2_pix);
        end else begin
          logic [29:0] e; string r;
          e = q2.pop_front(); r = t2.pop_front();
          if (o2_pix !== e) begin
            errors++;
            $display("FAIL %s link2: actual %h expected %h", r, o2_pix, e);
          end
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic v1, input logic [29:0] p1,
                       input logic v2, input logic [29:0] p2);
    l1_vld = v1; l1_pix = p1; l2_vld = v2; l2_pix = p2;
    @(negedge clk);
    l1_vld = 1'b0; l2_vld = 1'b0;
  endtask

  task automatic exp1(input logic [29:0] p, input string r);
    q1.push_back(p); t1.push_back(r);
  endtask
  task automatic exp2(input logic [29:0] p, input string r);
    q2.push_back(p); t2.push_back(r);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    idle(2);
  endtask

  task automatic drain(input string r);
    idle(3);
    chk({r, " queue1 drained"}, q1.size(), 0);
    chk({r, " queue2 drained"}, q2.size(), 0);
    q1.delete(); t1.delete(); q2.delete(); t2.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; pwr_dn = 1'b0;
    l1_clk_ok = 1'b1; l2_clk_ok = 1'b1;
    l1_lane_ok = 5'h1f; l2_lane_ok = 5'h1f;
    l1_vld = 1'b0; l2_vld = 1'b0; l1_pix = '0; l2_pix = '0;
    idle(3);
    // R10 reset state
    chk("R10 en1", o1_en, 0); chk("R10 en2", o2_en, 0);
    chk("R10 vld", {o1_vld, o2_vld}, 0);
    chk("R10 pix", o1_pix | o2_pix, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R10 first cycle vld", {o1_vld, o2_vld}, 0);
    idle(4);
    chk("R1 en after reset", {o1_en, o2_en}, 2'b11);

    // R1 pass-through
    exp1(30'h1234567, "R1"); exp2(30'h2abcdef0, "R1");
    drive(1, 30'h1234567, 1, 30'h2abcdef0);
    exp1(30'h0f0f0f0, "R1");
    drive(1, 30'h0f0f0f0, 0, 30'h3fffffff);
    exp2(30'h15555555, "R1");
    drive(0, 30'h0, 1, 30'h15555555);
    drain("R1");

    // R8 lane masking: lane B of link 1 and lane E of link 2 absent
    l1_lane_ok = 5'b11101; l2_lane_ok = 5'b01111;
    exp1(30'h3fffffff & ~30'h00000fc0, "R8");
    exp2(30'h3fffffff & ~30'h3f000000, "R8");
    drive(1, 30'h3fffffff, 1, 30'h3fffffff);
    drain("R8");
    l1_lane_ok = 5'h1f; l2_lane_ok = 5'h1f;

    // R7 link2 clock absent in pass-through: link2 counted invalid
    l2_clk_ok = 1'b0;
    exp1(30'h111, "R7");
    drive(1, 30'h111, 1, 30'h222);
    drain("R7 pass");

    // R2 duplication, link2 ignored (clock still absent, then present)
    set_mode(2'b10);
    exp1(30'h0abcabc, "R2"); exp2(30'h0abcabc, "R2");
    drive(1, 30'h0abcabc, 1, 30'h3333333);
    l2_clk_ok = 1'b1;
    idle(1);
    drive(0, 30'h0, 1, 30'h3333333);
    exp1(30'h2468ace, "R2"); exp2(30'h2468ace, "R2");
    drive(1, 30'h2468ace, 1, 30'h1357bdf);
    idle(1);
    chk("R2 enables", {o1_en, o2_en}, 2'b11);
    drain("R2");

    // R3 split, R7 link2 clock ignored in split
    set_mode(2'b11);
    l2_clk_ok = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i % 2 == 0) exp1(30'h100 + i, "R3");
      else            exp2(30'h100 + i, "R3");
      drive(1, 30'h100 + i, 1, 30'h3000000);
      idle(1);
    end
    drain("R3");
    // R3 odd-pixel timing: after pixel 0 nothing; after pixel 1 both together
    drive(1, 30'h55, 0, 0);
    chk("R3 held no output", {o1_vld, o2_vld}, 2'b00);
    exp1(30'h55, "R3"); exp2(30'h66, "R3");
    drive(1, 30'h66, 0, 0);
    chk("R3 pair together", {o1_vld, o2_vld}, 2'b11);
    drain("R3 timing");
    l2_clk_ok = 1'b1;

    // R9 mode change clears phase, drops pixel on change cycle
    drive(1, 30'h0dead, 0, 0);          // held even pixel
    set_mode(2'b00);
    set_mode(2'b11);
    exp1(30'h0beef, "R9"); exp2(30'h0cafe, "R9");
    drive(1, 30'h0beef, 0, 0);
    drive(1, 30'h0cafe, 0, 0);
    drain("R9 phase");
    mode = 2'b10;
    drive(1, 30'h0f00d, 0, 0);          // on change cycle: discarded
    chk("R9 change cycle quiet", {o1_vld, o2_vld}, 2'b00);
    drain("R9 drop");

    // R4 merge
    set_mode(2'b01);
    exp1(30'h0a1, "R4"); exp1(30'h0b1, "R4");
    drive(1, 30'h0a1, 1, 30'h0b1);
    chk("R4 first", o1_pix, 30'h0a1);
    @(negedge clk);
    chk("R4 second next cycle", o1_pix, 30'h0b1);
    chk("R4 link2 off", {o2_en, o2_vld}, 2'b00);
    exp1(30'h0a2, "R4"); exp1(30'h0b2, "R4");
    drive(1, 30'h0a2, 1, 30'h0b2);
    idle(1);
    drive(1, 30'h0a3, 0, 0);            // lone link1: no pair
    // R7 link2 clock absent in merge: no pair formed
    l2_clk_ok = 1'b0;
    drive(1, 30'h0a4, 1, 30'h0b4);
    l2_clk_ok = 1'b1;
    drain("R4");

    // R5 power-down
    set_mode(2'b11);
    drive(1, 30'h777, 0, 0);            // even held
    pwr_dn = 1'b1;
    drive(1, 30'h778, 0, 0);
    chk("R5 enables off", {o1_en, o2_en}, 2'b00);
    chk("R5 vld off", {o1_vld, o2_vld}, 2'b00);
    pwr_dn = 1'b0;
    idle(1);
    exp1(30'h779, "R5"); exp2(30'h77a, "R5");
    drive(1, 30'h779, 0, 0);
    drive(1, 30'h77a, 0, 0);
    drain("R5");

    // R6 link1 clock loss
    set_mode(2'b10);
    l1_clk_ok = 1'b0;
    drive(1, 30'h999, 0, 0);
    chk("R6 enables off", {o1_en, o2_en}, 2'b00);
    chk("R6 vld off", {o1_vld, o2_vld}, 2'b00);
    l1_clk_ok = 1'b1;
    idle(1);
    chk("R6 enables back", {o1_en, o2_en}, 2'b11);
    drain("R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule